// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block sits between four peripheral DMA request lines and the CPU's bus-hold handshake. Each request line is brought into the clock domain through a synchronizer and masked by its channel's enable bit. The block raises one shared hold request to the CPU when any enabled channel is asking. Once the CPU answers with hold acknowledge, it grants the highest-priority channel by pulling that channel's active-low acknowledge line down for one transfer. The granted channel index and a valid flag go to the transfer sequencer, which does the address and count work.

Every transfer takes four clock states, T1 to T4. The acknowledge is low during T2 and T3 only, so it pulses once per byte, even within a burst. The synchronized, enabled requests are sampled in T4. If any request is active there, the next transfer starts straight away for the winner of a fresh arbitration, and the bus stays held. A higher-priority request can therefore take over a lower-priority burst at a transfer boundary. If no request is active at T4, the transfer ends, hold is dropped and the block goes idle. A mode input selects fixed priority, where channel 0 is highest. It can instead select rotating priority, where the channel just served falls to the bottom.

Top module: `dma_req_arbiter`

## Requirements
- R1: While reset is asserted and right after it, hold_req_o is 0, dack_n_o is all ones and grant_vld_o is 0. The registered enables are cleared, and the rotating priority pointer makes channel 0 the highest.
- R2: hold_req_o rises when any enabled, synchronized request is active. It stays high for as long as grant_vld_o is high.
- R3: No acknowledge is given and grant_vld_o stays 0 until hold_ack_i is seen high while hold is requested. A transfer starts only on a cycle that follows hold_ack_i high.
- R4: With rotate_i = 0, the active enabled channel with the lowest index wins (channel 0 highest, channel 3 lowest).
- R5: With rotate_i = 1, the search for the winner starts at a pointer and wraps upward. After every transfer the pointer becomes (served channel + 1) mod 4, so the served channel becomes lowest priority.
- R6: While an enabled request stays high, transfers follow back to back without hold_req_o dropping.
- R7: Requests are sampled in T4 of each transfer, and the winner of that sample is served in the next transfer. A newly raised higher-priority request overrides a running lower-priority burst within two transfers.
- R8: If no enabled request is active at the T4 sample, the transfer completes and hold_req_o falls together with grant_vld_o. The block then returns to idle.
- R9: dack_n_o has at most one bit low at a time. Each transfer pulls the granted bit low for exactly 2 clock cycles (T2, T3) and then returns it high, so there is one pulse per byte.
- R10: A request on a channel whose chan_en_i bit is 0 is ignored. It raises no hold request and gets no acknowledge.
- R11: While a dack_n_o bit is low, grant_vld_o is 1 and grant_idx_o equals the index of that bit.
- R12: A request raised on an idle block takes three rising edges to reach hold_req_o: two synchronizer flops and the idle state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dreq_i | input | 4 | Asynchronous request lines, one per channel |
| chan_en_i | input | 4 | Enable bits, one per channel, registered internally |
| rotate_i | input | 1 | 1 selects rotating priority, 0 selects fixed priority |
| hold_ack_i | input | 1 | Hold acknowledge from the CPU |
| hold_req_o | output | 1 | Composite bus-hold request |
| dack_n_o | output | 4 | Active-low acknowledge, one per channel |
| grant_idx_o | output | 2 | Index of the channel being served |
| grant_vld_o | output | 1 | High during the four states of a transfer |

## Verification
A wrong priority pointer or a lost grant register shows at the ports on the very next acknowledge pulse: the wrong dack_n_o bit goes low, or grant_idx_o disagrees with it. A sweep over every request pattern, in several enable masks and both modes, compares each pulse against an arithmetic model of the pointer. A stuck transfer state shows within one four-cycle transfer as a pulse that is not two cycles long, or as hold that never drops after the requests are released. A wrong synchronizer depth shows as hold_req_o rising one edge early or late.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_T4
    } arb_state_e;
endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
    parameter int NCH    = 4,
    parameter int STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] async_i,
    output logic [NCH-1:0] sync_o
);
    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_ch
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_i[c]};
            end
            assign sync_o[c] = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter int NCH  = 4,
    parameter int CH_W = 2
) (
    input  logic [NCH-1:0]  req_i,
    input  logic [CH_W-1:0] base_i,
    output logic [CH_W-1:0] win_o,
    output logic            any_o
);
    always_comb begin
        int sum;
        win_o = '0;
        any_o = |req_i;
        // search downward so the lowest offset from base is the last one written
        for (int i = NCH - 1; i >= 0; i--) begin
            sum = int'(base_i) + i;
            if (sum >= NCH) sum = sum - NCH;
            if (req_i[sum]) win_o = CH_W'(sum);
        end
    end
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
    parameter int NCH         = 4,
    parameter int SYNC_STAGES = 2,
    localparam int CH_W       = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  dreq_i,
    input  logic [NCH-1:0]  chan_en_i,
    input  logic            rotate_i,
    input  logic            hold_ack_i,
    output logic            hold_req_o,
    output logic [NCH-1:0]  dack_n_o,
    output logic [CH_W-1:0] grant_idx_o,
    output logic            grant_vld_o
);
    import dma_arb_pkg::*;

    typedef struct packed {
        arb_state_e      st;
        logic [CH_W-1:0] grant;
        logic [CH_W-1:0] ptr;
        logic [NCH-1:0]  en;
    } arb_reg_t;

    arb_reg_t r_d, r_q;

    logic [NCH-1:0]  req_sync;
    logic [NCH-1:0]  req_m;
    logic [CH_W-1:0] after_grant;
    logic [CH_W-1:0] base;
    logic [CH_W-1:0] win;
    logic            win_any;

    dma_req_sync #(
        .NCH    (NCH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (dreq_i),
        .sync_o  (req_sync)
    );

    assign req_m = req_sync & r_q.en;

    // channel just served moves to the bottom: pointer = served + 1, wrapped
    always_comb begin
        if (r_q.grant == CH_W'(NCH - 1)) after_grant = '0;
        else                             after_grant = r_q.grant + 1'b1;
        if (!rotate_i)                 base = '0;
        else if (r_q.st == ST_T4)      base = after_grant;
        else                           base = r_q.ptr;
    end

    dma_prio_pick #(
        .NCH  (NCH),
        .CH_W (CH_W)
    ) u_pick (
        .req_i  (req_m),
        .base_i (base),
        .win_o  (win),
        .any_o  (win_any)
    );

    always_comb begin
        r_d    = r_q;
        r_d.en = chan_en_i;
        unique case (r_q.st)
            ST_IDLE: begin
                if (win_any) r_d.st = ST_HOLD;
            end
            ST_HOLD: begin
                if (hold_ack_i) begin
                    if (win_any) begin
                        r_d.st    = ST_T1;
                        r_d.grant = win;
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end
            end
            ST_T1: r_d.st = ST_T2;
            ST_T2: r_d.st = ST_T3;
            ST_T3: r_d.st = ST_T4;
            ST_T4: begin
                r_d.ptr = after_grant;
                if (win_any) begin
                    r_d.st    = ST_T1;
                    r_d.grant = win;
                end else begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.grant <= '0;
            r_q.ptr   <= '0;
            r_q.en    <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign hold_req_o  = (r_q.st != ST_IDLE);
    assign grant_vld_o = (r_q.st == ST_T1) || (r_q.st == ST_T2) ||
                         (r_q.st == ST_T3) || (r_q.st == ST_T4);
    assign grant_idx_o = r_q.grant;

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            dack_n_o[i] = !(((r_q.st == ST_T2) || (r_q.st == ST_T3)) &&
                            (r_q.grant == CH_W'(i)));
        end
    end
endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk #(
    parameter int NCH  = 4,
    parameter int CH_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            hold_ack_i,
    input logic            hold_req_o,
    input logic [NCH-1:0]  dack_n_o,
    input logic [CH_W-1:0] grant_idx_o,
    input logic            grant_vld_o
);
    logic ack_any;
    assign ack_any = (dack_n_o != {NCH{1'b1}});

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_idle_chk: assert (!hold_req_o && !grant_vld_o && dack_n_o == {NCH{1'b1}});
        end
    end

    // R2
    vld_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld_o |-> hold_req_o);

    // R3
    start_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_vld_o) |-> $past(hold_ack_i));

    // R3
    ack_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_any |-> hold_req_o);

    // R8
    release_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grant_vld_o) |-> !hold_req_o);

    // R9
    ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~dack_n_o));

    // R9
    pulse_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_any) |=> ack_any);

    // R9
    pulse_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_any && $past(ack_any)) |=> !ack_any);

    // R11
    idx_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_any |-> (grant_vld_o && dack_n_o[grant_idx_o] == 1'b0));
endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(
    .NCH  (NCH),
    .CH_W (CH_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_ack_i  (hold_ack_i),
    .hold_req_o  (hold_req_o),
    .dack_n_o    (dack_n_o),
    .grant_idx_o (grant_idx_o),
    .grant_vld_o (grant_vld_o)
);

// File: tb/tb_dma_req_arbiter.sv
module tb_dma_req_arbiter;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] dreq = '0;
    logic [3:0] chan_en = '0;
    logic       rotate = 1'b0;
    logic       hold_ack = 1'b0;
    logic       hold_req;
    logic [3:0] dack_n;
    logic [1:0] grant_idx;
    logic       grant_vld;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int mptr = 0;
    int seen = 0;
    int lowcnt = 0;
    int last_idx = 0;
    bit prev_hi = 1'b1;

    always #(CLK_P / 2) clk = ~clk;

    dma_req_arbiter dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .dreq_i      (dreq),
        .chan_en_i   (chan_en),
        .rotate_i    (rotate),
        .hold_ack_i  (hold_ack),
        .hold_req_o  (hold_req),
        .dack_n_o    (dack_n),
        .grant_idx_o (grant_idx),
        .grant_vld_o (grant_vld)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog R6 act=%0d exp=%0d", cycles, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    function automatic int low_idx(input logic [3:0] v);
        for (int i = 0; i < 4; i++) if (!v[i]) return i;
        return -1;
    endfunction

    function automatic int model_pick(input logic [3:0] m);
        int b;
        b = rotate ? mptr : 0;
        for (int i = 0; i < 4; i++) if (m[(b + i) % 4]) return (b + i) % 4;
        return -1;
    endfunction

    task automatic do_reset;
        rst_n = 1'b0;
        dreq = '0;
        chan_en = '0;
        repeat (3) tick;
        // R1: outputs idle while reset is held
        chk(!hold_req && dack_n == 4'hf && !grant_vld, "R1 in reset", {hold_req, grant_vld}, 0);
        rst_n = 1'b1;
        mptr = 0;
        prev_hi = 1'b1;
        lowcnt = 0;
        tick;
    endtask

    // called once per negedge: observes acknowledge pulses against the model
    task automatic monitor(input logic [3:0] m, input bit check_pick);
        int got, exp;
        if (dack_n != 4'hf) begin
            lowcnt++;
            if (prev_hi) begin
                got = low_idx(dack_n);
                chk($countones(~dack_n) == 1, "R9 onehot", int'(dack_n), 0);
                chk(int'(grant_idx) == got && grant_vld, "R11 index", int'(grant_idx), got);
                chk(hold_req, "R6 hold kept", int'(hold_req), 1);
                if (check_pick) begin
                    exp = model_pick(m);
                    if (rotate) chk(got == exp, "R5 rotate pick", got, exp);
                    else        chk(got == exp, "R4 fixed pick", got, exp);
                end
                mptr = (got + 1) % 4;
                last_idx = got;
                seen++;
            end
        end else if (!prev_hi) begin
            chk(lowcnt == 2, "R9 pulse width", lowcnt, 2);
            lowcnt = 0;
        end
        prev_hi = (dack_n == 4'hf);
    endtask

    task automatic run_pat(input logic [3:0] rq, input logic [3:0] en, input int ntr);
        logic [3:0] m;
        int cyc;
        m = rq & en;
        chan_en = en;
        dreq = rq;
        seen = 0;
        if (m == 4'b0) begin
            repeat (12) tick;
            // R10: disabled or absent requests give nothing
            chk(!hold_req && dack_n == 4'hf, "R10 ignored", {hold_req, dack_n}, 15);
            dreq = '0;
            tick;
            return;
        end
        cyc = 0;
        while (seen < ntr && cyc < 400) begin
            tick;
            cyc++;
            monitor(m, 1'b1);
        end
        chk(seen >= ntr, "R6 burst count", seen, ntr);
        dreq = '0;
        cyc = 0;
        while ((hold_req || !prev_hi) && cyc < 100) begin
            tick;
            cyc++;
            monitor(m, 1'b1);
        end
        // R8: idle after release
        chk(!hold_req && !grant_vld, "R8 release", {hold_req, grant_vld}, 0);
        repeat (3) tick;
    endtask

    initial begin
        logic [3:0] masks [4];
        masks[0] = 4'hf;
        masks[1] = 4'h5;
        masks[2] = 4'ha;
        masks[3] = 4'h0;

        hold_ack = 1'b1;
        do_reset;
        chk(!hold_req && dack_n == 4'hf && !grant_vld, "R1 after reset", {hold_req, grant_vld}, 0);

        // R12: synchronizer plus idle register latency
        chan_en = 4'b0100;
        tick;
        dreq = 4'b0100;
        tick;
        chk(!hold_req, "R12 edge1", int'(hold_req), 0);
        tick;
        chk(!hold_req, "R12 edge2", int'(hold_req), 0);
        tick;
        chk(hold_req, "R12 edge3", int'(hold_req), 1);
        dreq = '0;
        repeat (20) tick;

        // R3: no acknowledge without hold acknowledge
        do_reset;
        hold_ack = 1'b0;
        chan_en = 4'hf;
        dreq = 4'b0010;
        begin
            bit any_low;
            any_low = 1'b0;
            repeat (25) begin
                tick;
                if (dack_n != 4'hf || grant_vld) any_low = 1'b1;
            end
            chk(!any_low, "R3 gated", int'(any_low), 0);
            chk(hold_req, "R2 hold raised", int'(hold_req), 1);
        end
        hold_ack = 1'b1;
        seen = 0;
        for (int k = 0; k < 20 && seen == 0; k++) begin
            tick;
            monitor(4'b0010, 1'b1);
        end
        chk(seen == 1 && last_idx == 1, "R3 granted after ack", last_idx, 1);
        dreq = '0;
        repeat (20) tick;
        prev_hi = 1'b1;
        lowcnt = 0;

        // R7: higher priority request overrides a running burst (fixed mode)
        do_reset;
        rotate = 1'b0;
        chan_en = 4'hf;
        dreq = 4'b1000;
        seen = 0;
        for (int k = 0; k < 200 && seen < 2; k++) begin
            tick;
            monitor(4'b1000, 1'b1);
        end
        chk(last_idx == 3, "R7 low burst", last_idx, 3);
        dreq = 4'b1001;
        seen = 0;
        for (int k = 0; k < 300 && seen < 6; k++) begin
            tick;
            monitor(4'b1001, 1'b0);
            if (seen >= 3 && dack_n != 4'hf && lowcnt == 1)
                chk(last_idx == 0, "R7 preempt", last_idx, 0);
        end
        chk(seen >= 6 && last_idx == 0, "R7 settled", last_idx, 0);
        dreq = '0;
        for (int k = 0; k < 60; k++) begin
            tick;
            monitor(4'b1001, 1'b0);
        end

        // R4 / R5 / R10 sweeps over all patterns in both modes
        for (int r = 0; r < 2; r++) begin
            rotate = r[0];
            do_reset;
            for (int e = 0; e < 4; e++) begin
                for (int p = 0; p < 16; p++) begin
                    run_pat(4'(p), masks[e], 6);
                end
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule